// File: doc/BRIEF.md
# Eviction-Fed Victim Cache Controller

This block is a victim store placed under a private upper-level cache. It never fetches from memory: the only way a line enters it is an eviction pushed down from the level above. Because of this the two levels are non-inclusive, so a line may sit above without a copy here. Requests arrive on one channel. A request flag selects between an eviction, which carries data, and a lookup, which carries the ID of the requesting core.

Each stored line keeps the ID of the last core that touched it and a sticky sharing flag. A lookup from a new ID marks the line shared. When a lookup hits a shared line, the block returns the data and keeps the line resident. When a lookup hits a line that only one core has touched, the block returns the data and drops the line, which frees the slot for later victims. A lookup miss goes out on the memory-side port and allocates nothing. Storage is split into interleaved sub-caches chosen by the low address bits. Within a set, ways are filled in invalid-first order and then replaced by a rotating per-set pointer.

Top module: `victim_cache`

## Requirements
- R1: After reset every line is invalid, and `respValid` and `memReqValid` are low until a request is served.
- R2: An eviction whose address is not resident allocates a line. It stores the address tag, the data and the evicting ID, with the sharing flag clear.
- R3: A lookup that misses gives `respHit`=0. In the same cycle it raises `memReqValid` with `memReqAddr` and `memReqId` equal to the request. It allocates nothing, so repeating the lookup misses again.
- R4: A lookup hit keeps the line resident when the line is already marked shared or the requester ID differs from the recorded ID. The response has `respHit`=1, `respKept`=1 and the stored data. The line becomes shared and records the new ID.
- R5: A lookup hit on an unshared line with a matching ID returns the data with `respKept`=0 and invalidates the line, so the next lookup of that address misses.
- R6: An eviction to a resident address overwrites that line's data in place and never creates a second copy.
- R7: An eviction to a resident address from a different ID marks the line shared, so a later lookup of it keeps the line.
- R8: Address bits [1:0] select the sub-cache, bits [3:2] select the set within it, and the remaining upper bits form the tag. Lines that share a tag but differ in any of bits [3:0] are distinct.
- R9: Way choice on allocation takes the lowest-numbered invalid way. When the set is full, the way named by the set's rotating pointer is replaced. The pointer starts at 0 after reset and advances by one, wrapping, after each replacement in a full set.
- R10: Every response and memory request is registered and appears one cycle after its request. A lookup always raises `respValid` and echoes its ID on `respId`. An eviction raises neither `respValid` nor `memReqValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present this cycle |
| reqEvict | input | 1 | 1 = eviction from the upper level, 0 = lookup |
| reqAddr | input | ADDR_W | Line address |
| reqId | input | ID_W | Requesting core ID |
| reqData | input | DATA_W | Line data carried by an eviction |
| respValid | output | 1 | Lookup response present |
| respHit | output | 1 | Lookup found the line |
| respKept | output | 1 | Hit line stays resident (1) or was handed back and dropped (0) |
| respData | output | DATA_W | Data of the hit line |
| respId | output | ID_W | ID of the lookup being answered |
| memReqValid | output | 1 | Lookup miss forwarded to memory |
| memReqAddr | output | ADDR_W | Address of the forwarded miss |
| memReqId | output | ID_W | ID of the forwarded miss |

## Verification
The bench targets the keep-or-move choice. A design that inverts or ignores the ID comparison would either keep private lines, which wastes capacity, or drop shared ones, so a second requester would miss. It repeats evictions to a resident address. A design that allocated a duplicate would later return stale data after the fresh copy was moved out. It also fills a set beyond its ways, where a wrong rotating pointer or a skipped invalid-first search would evict the wrong tag. It issues lookups that miss twice in a row, where any allocation on a miss would turn the second lookup into a hit.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef struct packed {
    logic respond;
    logic hit;
    logic keep;
    logic inval;
    logic memReq;
    logic update;
    logic alloc;
    logic bumpPtr;
    logic markShared;
  } vc_strobe_t;

endpackage

// File: rtl/vc_control.sv
module vc_control
  import vc_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int ID_W  = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reqValid,
  input  logic                        reqEvict,
  input  logic [TAG_W-1:0]            reqTag,
  input  logic [ID_W-1:0]             reqId,
  input  logic [WAYS-1:0]             setValid,
  input  logic [WAYS-1:0][TAG_W-1:0]  setTags,
  input  logic [WAYS-1:0][ID_W-1:0]   setIds,
  input  logic [WAYS-1:0]             setShared,
  input  logic [WAY_W-1:0]            setPtr,
  output vc_strobe_t                  strobe,
  output logic [WAY_W-1:0]            ctrlWay
);

  logic [WAYS-1:0]  hitVec;
  logic             anyHit;
  logic             anyFree;
  logic [WAY_W-1:0] hitWay;
  logic [WAY_W-1:0] freeWay;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = setValid[w] && (setTags[w] == reqTag);
  end

  assign anyHit  = |hitVec;
  assign anyFree = ~&setValid;

  always_comb begin
    hitWay  = '0;
    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w])    hitWay  = WAY_W'(w);
      if (!setValid[w]) freeWay = WAY_W'(w);
    end
  end

  always_comb begin
    strobe  = '0;
    ctrlWay = '0;
    if (reqValid) begin
      if (!reqEvict) begin
        strobe.respond = 1'b1;
        if (anyHit) begin
          strobe.hit = 1'b1;
          ctrlWay    = hitWay;
          if (setShared[hitWay] || (setIds[hitWay] != reqId)) begin
            strobe.keep       = 1'b1;
            strobe.markShared = 1'b1;
          end else begin
            strobe.inval = 1'b1;
          end
        end else begin
          strobe.memReq = 1'b1;
        end
      end else if (anyHit) begin
        strobe.update     = 1'b1;
        ctrlWay           = hitWay;
        strobe.markShared = (setIds[hitWay] != reqId);
      end else begin
        strobe.alloc   = 1'b1;
        ctrlWay        = anyFree ? freeWay : setPtr;
        strobe.bumpPtr = !anyFree;
      end
    end
  end

  // R6: a set never holds two valid copies of one tag
  assert_single_copy_R6: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> $countones(hitVec) <= 1);

endmodule

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int ID_W   = 2,
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int BANKS  = 4,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int IDX_W   = $clog2(BANKS) + $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W,
  localparam int ENTRIES = BANKS * SETS,
  localparam int CNT_W   = $clog2(ENTRIES * WAYS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reqValid,
  input  logic                        reqEvict,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [ID_W-1:0]             reqId,
  input  logic [DATA_W-1:0]           reqData,
  input  vc_strobe_t                  strobe,
  input  logic [WAY_W-1:0]            ctrlWay,
  output logic [TAG_W-1:0]            reqTag,
  output logic [WAYS-1:0]             setValid,
  output logic [WAYS-1:0][TAG_W-1:0]  setTags,
  output logic [WAYS-1:0][ID_W-1:0]   setIds,
  output logic [WAYS-1:0]             setShared,
  output logic [WAY_W-1:0]            setPtr,
  output logic                        respValid,
  output logic                        respHit,
  output logic                        respKept,
  output logic [DATA_W-1:0]           respData,
  output logic [ID_W-1:0]             respId,
  output logic                        memReqValid,
  output logic [ADDR_W-1:0]           memReqAddr,
  output logic [ID_W-1:0]             memReqId
);

  logic [WAYS-1:0]                validArr  [ENTRIES];
  logic [WAYS-1:0][TAG_W-1:0]     tagArr    [ENTRIES];
  logic [WAYS-1:0][DATA_W-1:0]    dataArr   [ENTRIES];
  logic [WAYS-1:0][ID_W-1:0]      idArr     [ENTRIES];
  logic [WAYS-1:0]                sharedArr [ENTRIES];
  logic [WAY_W-1:0]               ptrArr    [ENTRIES];

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] totalValid;

  assign idx       = reqAddr[IDX_W-1:0];
  assign reqTag    = reqAddr[ADDR_W-1:IDX_W];
  assign setValid  = validArr[idx];
  assign setTags   = tagArr[idx];
  assign setIds    = idArr[idx];
  assign setShared = sharedArr[idx];
  assign setPtr    = ptrArr[idx];

  always_comb begin
    totalValid = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      totalValid = totalValid + CNT_W'($countones(validArr[e]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        validArr[e]  <= '0;
        tagArr[e]    <= '0;
        dataArr[e]   <= '0;
        idArr[e]     <= '0;
        sharedArr[e] <= '0;
        ptrArr[e]    <= '0;
      end
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respKept    <= 1'b0;
      respData    <= '0;
      respId      <= '0;
      memReqValid <= 1'b0;
      memReqAddr  <= '0;
      memReqId    <= '0;
    end else begin
      respValid   <= strobe.respond;
      respHit     <= strobe.hit;
      respKept    <= strobe.keep;
      respData    <= strobe.hit ? dataArr[idx][ctrlWay] : '0;
      respId      <= reqId;
      memReqValid <= strobe.memReq;
      memReqAddr  <= reqAddr;
      memReqId    <= reqId;

      if (strobe.inval) validArr[idx][ctrlWay] <= 1'b0;

      if (strobe.keep || strobe.update) begin
        idArr[idx][ctrlWay] <= reqId;
        if (strobe.markShared) sharedArr[idx][ctrlWay] <= 1'b1;
      end

      if (strobe.update) dataArr[idx][ctrlWay] <= reqData;

      if (strobe.alloc) begin
        validArr[idx][ctrlWay]  <= 1'b1;
        tagArr[idx][ctrlWay]    <= reqTag;
        dataArr[idx][ctrlWay]   <= reqData;
        idArr[idx][ctrlWay]     <= reqId;
        sharedArr[idx][ctrlWay] <= 1'b0;
      end

      if (strobe.bumpPtr) begin
        ptrArr[idx] <= (ptrArr[idx] == WAY_W'(WAYS - 1)) ? '0 : ptrArr[idx] + 1'b1;
      end
    end
  end

  // R2: occupancy grows only after an eviction request
  assert_alloc_from_evict_R2: assert property (@(posedge clk) disable iff (rst)
    totalValid > $past(totalValid) |-> $past(reqValid && reqEvict));

  // R3: a memory request is always a missed lookup response
  assert_miss_forward_R3: assert property (@(posedge clk) disable iff (rst)
    memReqValid |-> respValid && !respHit);

  // R4: only a hit can report a retained line
  assert_kept_is_hit_R4: assert property (@(posedge clk) disable iff (rst)
    respKept |-> respHit);

  // R5: a line handed back frees one slot
  assert_move_frees_R5: assert property (@(posedge clk) disable iff (rst)
    respValid && respHit && !respKept |-> totalValid < $past(totalValid));

  // R10: lookups only produce responses
  assert_resp_from_lookup_R10: assert property (@(posedge clk) disable iff (rst)
    respValid |-> $past(reqValid && !reqEvict));

endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int ID_W   = 2,
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int BANKS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqEvict,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ID_W-1:0]   reqId,
  input  logic [DATA_W-1:0] reqData,
  output logic              respValid,
  output logic              respHit,
  output logic              respKept,
  output logic [DATA_W-1:0] respData,
  output logic [ID_W-1:0]   respId,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ID_W-1:0]   memReqId
);

  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(BANKS) + $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  vc_strobe_t                 strobe;
  logic [WAY_W-1:0]           ctrlWay;
  logic [TAG_W-1:0]           reqTag;
  logic [WAYS-1:0]            setValid;
  logic [WAYS-1:0][TAG_W-1:0] setTags;
  logic [WAYS-1:0][ID_W-1:0]  setIds;
  logic [WAYS-1:0]            setShared;
  logic [WAY_W-1:0]           setPtr;

  vc_control #(
    .WAYS(WAYS), .TAG_W(TAG_W), .ID_W(ID_W)
  ) u_control (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqEvict(reqEvict), .reqTag(reqTag), .reqId(reqId),
    .setValid(setValid), .setTags(setTags), .setIds(setIds),
    .setShared(setShared), .setPtr(setPtr),
    .strobe(strobe), .ctrlWay(ctrlWay)
  );

  vc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
    .WAYS(WAYS), .SETS(SETS), .BANKS(BANKS)
  ) u_datapath (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqEvict(reqEvict), .reqAddr(reqAddr),
    .reqId(reqId), .reqData(reqData),
    .strobe(strobe), .ctrlWay(ctrlWay),
    .reqTag(reqTag), .setValid(setValid), .setTags(setTags),
    .setIds(setIds), .setShared(setShared), .setPtr(setPtr),
    .respValid(respValid), .respHit(respHit), .respKept(respKept),
    .respData(respData), .respId(respId),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqId(memReqId)
  );

endmodule

// File: tb/victim_cache_bench.sv
`timescale 1ns/1ps
module victim_cache_bench;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int ID_W   = 2;
  localparam int WAYS   = 2;
  localparam int NIDX   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqEvict = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [ID_W-1:0]   reqId = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic respValid, respHit, respKept, memReqValid;
  logic [DATA_W-1:0] respData;
  logic [ID_W-1:0]   respId, memReqId;
  logic [ADDR_W-1:0] memReqAddr;

  int checks = 0;
  int errors = 0;

  // reference state
  logic        mVal  [NIDX][WAYS];
  logic [7:0]  mTag  [NIDX][WAYS];
  logic [15:0] mData [NIDX][WAYS];
  logic [1:0]  mId   [NIDX][WAYS];
  logic        mSh   [NIDX][WAYS];
  int          mPtr  [NIDX];

  always #2.5 clk = ~clk;

  victim_cache u_victim_cache (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqEvict(reqEvict), .reqAddr(reqAddr),
    .reqId(reqId), .reqData(reqData),
    .respValid(respValid), .respHit(respHit), .respKept(respKept),
    .respData(respData), .respId(respId),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqId(memReqId)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int findWay(int ix, logic [7:0] tg);
    for (int w = 0; w < WAYS; w++) if (mVal[ix][w] && mTag[ix][w] == tg) return w;
    return -1;
  endfunction

  // one request; label "" picks the requirement from the expected outcome
  task automatic issue(logic ev, logic [11:0] a, logic [1:0] id, logic [15:0] d, string label);
    int ix, w;
    logic [7:0] tg;
    logic expHit, expKeep;
    logic [15:0] expData;
    string req;
    ix = int'(a[3:0]);
    tg = a[11:4];
    w = findWay(ix, tg);
    expHit = 1'b0; expKeep = 1'b0; expData = '0;
    if (!ev) begin
      if (w >= 0) begin
        expHit = 1'b1;
        expData = mData[ix][w];
        if (mSh[ix][w] || mId[ix][w] != id) begin
          expKeep = 1'b1; mSh[ix][w] = 1'b1; mId[ix][w] = id;
        end else begin
          mVal[ix][w] = 1'b0;
        end
      end
    end else if (w >= 0) begin
      mData[ix][w] = d;
      if (mId[ix][w] != id) mSh[ix][w] = 1'b1;
      mId[ix][w] = id;
    end else begin
      int v;
      v = -1;
      for (int k = WAYS - 1; k >= 0; k--) if (!mVal[ix][k]) v = k;
      if (v < 0) begin
        v = mPtr[ix];
        mPtr[ix] = (mPtr[ix] + 1) % WAYS;
      end
      mVal[ix][v] = 1'b1; mTag[ix][v] = tg; mData[ix][v] = d;
      mId[ix][v] = id; mSh[ix][v] = 1'b0;
    end
    if (label != "") req = label;
    else if (ev) req = "R10";
    else if (!expHit) req = "R3";
    else if (expKeep) req = "R4";
    else req = "R5";

    reqValid = 1'b1; reqEvict = ev; reqAddr = a; reqId = id; reqData = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (ev) begin
      check("R10", "evict respValid", 32'(respValid), 32'd0);
      check("R10", "evict memReqValid", 32'(memReqValid), 32'd0);
    end else begin
      check("R10", "respValid", 32'(respValid), 32'd1);
      check("R10", "respId", 32'(respId), 32'(id));
      check(req, "respHit", 32'(respHit), 32'(expHit));
      check(req, "memReqValid", 32'(memReqValid), 32'(!expHit));
      if (expHit) begin
        check(req, "respData", 32'(respData), 32'(expData));
        check(req, "respKept", 32'(respKept), 32'(expKeep));
      end else begin
        check(req, "memReqAddr", 32'(memReqAddr), 32'(a));
        check(req, "memReqId", 32'(memReqId), 32'(id));
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NIDX; i++) begin
      mPtr[i] = 0;
      for (int w = 0; w < WAYS; w++) begin
        mVal[i][w] = 1'b0; mTag[i][w] = '0; mData[i][w] = '0;
        mId[i][w] = '0; mSh[i][w] = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle outputs after reset, and nothing resident
    check("R1", "respValid after reset", 32'(respValid), 32'd0);
    check("R1", "memReqValid after reset", 32'(memReqValid), 32'd0);
    issue(1'b0, 12'h015, 2'd1, 16'h0, "R1");

    // R3: miss forwards and does not allocate
    issue(1'b0, 12'h2a7, 2'd2, 16'h0, "R3");
    issue(1'b0, 12'h2a7, 2'd2, 16'h0, "R3");

    // R2 and R5: private line is handed back and dropped
    issue(1'b1, 12'h131, 2'd1, 16'hbeef, "R2");
    issue(1'b0, 12'h131, 2'd1, 16'h0, "R5");
    issue(1'b0, 12'h131, 2'd1, 16'h0, "R5");

    // R4: second requester keeps the line; shared flag is sticky
    issue(1'b1, 12'h142, 2'd0, 16'h1111, "R2");
    issue(1'b0, 12'h142, 2'd2, 16'h0, "R4");
    issue(1'b0, 12'h142, 2'd0, 16'h0, "R4");
    issue(1'b0, 12'h142, 2'd0, 16'h0, "R4");

    // R6: repeated eviction updates in place, no stale duplicate
    issue(1'b1, 12'h153, 2'd1, 16'haaaa, "R6");
    issue(1'b1, 12'h153, 2'd1, 16'hbbbb, "R6");
    issue(1'b0, 12'h153, 2'd1, 16'h0, "R6");
    issue(1'b0, 12'h153, 2'd1, 16'h0, "R6");

    // R7: eviction from a new ID marks shared
    issue(1'b1, 12'h164, 2'd0, 16'h0c0c, "R7");
    issue(1'b1, 12'h164, 2'd3, 16'h0d0d, "R7");
    issue(1'b0, 12'h164, 2'd3, 16'h0, "R7");

    // R8: same tag, different sub-cache or set bits are distinct lines
    issue(1'b1, 12'h375, 2'd1, 16'h7575, "R8");
    issue(1'b0, 12'h374, 2'd1, 16'h0, "R8");
    issue(1'b0, 12'h371, 2'd1, 16'h0, "R8");
    issue(1'b0, 12'h375, 2'd2, 16'h0, "R8");

    // R9: fill a set past its ways
    issue(1'b1, 12'h016, 2'd0, 16'h0001, "R9");
    issue(1'b1, 12'h026, 2'd0, 16'h0002, "R9");
    issue(1'b1, 12'h036, 2'd0, 16'h0003, "R9");
    issue(1'b1, 12'h046, 2'd0, 16'h0004, "R9");
    issue(1'b0, 12'h016, 2'd1, 16'h0, "R9");
    issue(1'b0, 12'h026, 2'd1, 16'h0, "R9");
    issue(1'b0, 12'h036, 2'd1, 16'h0, "R9");
    issue(1'b0, 12'h046, 2'd1, 16'h0, "R9");
    issue(1'b1, 12'h056, 2'd0, 16'h0005, "R9");
    issue(1'b0, 12'h036, 2'd2, 16'h0, "R9");
    issue(1'b0, 12'h056, 2'd2, 16'h0, "R9");

    // mixed random traffic over a small tag pool
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      a = {8'($urandom % 4), 4'($urandom % 16)};
      issue(1'($urandom % 2), a, 2'($urandom % 4), 16'($urandom), "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule